// File: doc/BRIEF.md
# Multi-Mode Decrementer Timer

A 32-bit down-counter that loses one count on every cycle in which the timebase tick enable is high. Software can load it at any time through a write port. A two-bit mode select picks one of three ways the counter raises its interrupt:

- **Sticky status mode:** a flag is set when the count reaches 1 or 0.
- **Edge mode:** a pending flag latches when the count's top bit rises.
- **Level mode:** the line simply mirrors the top bit, that is, whether the value is negative.

A clear strobe acknowledges the flag. The block feeds an interrupt controller, which lies outside it.

The flag is one register shared by the two flag-based modes. In level mode nothing sets it, and it holds its value until it is cleared. The flag changes on the same clock edge that writes the new count. Because of that, the flag and the count always become visible in the same cycle.

Top module: `dec_timer`

## Requirements
- R1: While reset is asserted, `count` reads 0xFFFFFFFF and `status` and `irq` are 0.
- R2: Each cycle with `tick_en` high and `wr_en` low decrements `count` by one, wrapping from 0 to 0xFFFFFFFF. A cycle with neither strobe leaves `count` unchanged.
- R3: A cycle with `wr_en` high loads `wr_data` into `count`. The write wins over a simultaneous tick, so no decrement happens in that cycle.
- R4: `mode_sel` encoding: 2'b00 selects sticky status mode, 2'b01 selects edge mode, and 2'b10 and 2'b11 both select level mode.
- R5: In sticky status mode, any update that leaves `count` at 0 or 1 sets `status`. The update may be a tick or a write. An update leaving 2 or more does not set it, and `irq` equals `status`.
- R6: In edge mode, an update that takes bit 31 of `count` from 0 to 1 sets `status`. Both a wrap and a write count as such an update. An update where bit 31 was already 1 does not set `status`, and `irq` equals `status`.
- R7: In level mode, `irq` equals bit 31 of `count`, and counter updates do not set `status`.
- R8: A `sts_clr` pulse clears `status` on the next edge. If a set event occurs in the same cycle, the set wins and `status` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase tick; decrement enable |
| wr_en | input | 1 | Software load strobe |
| wr_data | input | 32 | Value to load |
| mode_sel | input | 2 | Interrupt mode (00 status, 01 edge, 1x level) |
| sts_clr | input | 1 | Clear strobe for the status flag |
| count | output | 32 | Current counter value |
| status | output | 1 | Interrupt status / pending flag |
| irq | output | 1 | Decrementer interrupt line |

## Verification
Two pairs of functions can land on the same edge: a software load against a tick, and a flag set against a clear strobe. The bench raises `wr_en` and `tick_en` together and expects the written value, not one less. It also pulses `sts_clr` in the very cycle a tick brings the count to 1, or makes bit 31 rise, and expects the flag to stay set. A further cycle with only `sts_clr` then shows that the clear itself works.

// File: rtl/dec_timer.sv
module dec_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   mode_sel,
  input  logic         sts_clr,
  output logic [W-1:0] count,
  output logic         status,
  output logic         irq
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam int TOP = W - 1;

  logic [W-1:0] cnt_q, cnt_nxt;
  logic         flag_q, upd, hit_low, msb_rise, set_evt;
  logic         m_status, m_edge, m_level;

  assign m_status = (mode_sel == 2'b00);
  assign m_edge   = (mode_sel == 2'b01);
  assign m_level  = mode_sel[1];

  assign upd     = wr_en | tick_en;
  assign cnt_nxt = wr_en ? wr_data : (tick_en ? cnt_q - 1'b1 : cnt_q);

  assign hit_low  = upd && (cnt_nxt[W-1:1] == '0);
  assign msb_rise = upd && cnt_nxt[TOP] && !cnt_q[TOP];
  assign set_evt  = (m_status && hit_low) || (m_edge && msb_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ALL_ONES;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      flag_q <= set_evt | (flag_q & ~sts_clr);
    end
  end

  assign count  = cnt_q;
  assign status = flag_q;
  assign irq    = rst_n & (m_level ? cnt_q[TOP] : flag_q);
endmodule

module dec_timer_props (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [1:0]  mode_sel,
  input logic        sts_clr,
  input logic [31:0] count,
  input logic        status,
  input logic        irq
);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count == $past(wr_data));
  assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en) |=> count == $past(count) - 32'd1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> $stable(count));
  assert_hit_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && !wr_en && tick_en && count == 32'd2) |=> status);
  assert_wrap_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && !wr_en && tick_en && count == 32'd0) |=> status);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !wr_en && !tick_en) |=> !status);
  assert_level_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[1] && !status) |=> !status);
endmodule

bind dec_timer dec_timer_props u_props (.*);

// File: tb/dec_timer_test.sv
`timescale 1ns/1ps
module dec_timer_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick_en = 0, wr_en = 0, sts_clr = 0;
  logic [31:0] wr_data = '0;
  logic [1:0]  mode_sel = 2'b00;
  logic [31:0] count;
  logic        status, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dec_timer uut (.clk, .rst_n, .tick_en, .wr_en, .wr_data, .mode_sel,
                 .sts_clr, .count, .status, .irq);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic w, input logic [31:0] d, input logic c);
    tick_en = t; wr_en = w; wr_data = d; sts_clr = c;
    @(posedge clk); @(negedge clk);
    tick_en = 0; wr_en = 0; sts_clr = 0;
  endtask

  task automatic t_reset;
    mode_sel = 2'b10;
    @(negedge clk);
    chk("R1 count", count, 32'hFFFFFFFF);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1; mode_sel = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_count;
    cyc(0, 1, 32'd5, 0);  chk("R3 load", count, 5);
    cyc(1, 0, 0, 0);      chk("R2 dec", count, 4);
    cyc(0, 0, 0, 0);      chk("R2 hold", count, 4);
    cyc(1, 1, 32'd9, 0);  chk("R3 write beats tick", count, 9);
    cyc(0, 1, 32'd0, 1);
    cyc(1, 0, 0, 0);      chk("R2 wrap", count, 32'hFFFFFFFF);
  endtask

  task automatic t_status_mode;
    mode_sel = 2'b00;
    cyc(0, 1, 32'd3, 1);  cyc(0, 0, 0, 1);
    chk("R5 start clear", status, 0);
    cyc(1, 0, 0, 0);      chk("R5 at 2 no set", status, 0);
    cyc(1, 0, 0, 0);      chk("R5 set at 1", status, 1);
    chk("R5 irq follows", irq, 1);
    cyc(0, 0, 0, 1);      chk("R8 clear", status, 0);
    chk("R5 irq cleared", irq, 0);
    cyc(1, 0, 0, 0);      chk("R5 set at 0", status, 1);
    cyc(0, 1, 32'd2, 1);  chk("R8 clear with write of 2", status, 0);
    cyc(1, 0, 0, 1);      chk("R8 set wins", status, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 1, 32'd0, 0);  chk("R5 write of 0 sets", status, 1);
  endtask

  task automatic t_edge_mode;
    mode_sel = 2'b01;
    cyc(0, 0, 0, 1);      chk("R6 start clear", status, 0);
    cyc(1, 0, 0, 0);      chk("R6 wrap rise", status, 1);
    chk("R6 irq follows", irq, 1);
    cyc(0, 0, 0, 1);      chk("R6 clear", irq, 0);
    cyc(0, 1, 32'h80000005, 0); chk("R6 msb already 1", status, 0);
    cyc(1, 0, 0, 0);      chk("R6 no rise on dec", status, 0);
    cyc(0, 1, 32'd1, 0);  chk("R6 falls to 1 no set", status, 0);
    cyc(0, 1, 32'h80000000, 0); chk("R6 write rise", status, 1);
    cyc(0, 1, 32'd0, 1);
    cyc(1, 0, 0, 1);      chk("R8 set wins edge", status, 1);
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_level_mode;
    mode_sel = 2'b10;
    cyc(0, 1, 32'h80000000, 1); chk("R7 irq on msb", irq, 1);
    chk("R7 status quiet", status, 0);
    cyc(0, 1, 32'd1, 0);  chk("R7 irq low", irq, 0);
    cyc(1, 0, 0, 0);      chk("R7 at 0 no status", status, 0);
    chk("R7 irq at 0", irq, 0);
    cyc(1, 0, 0, 0);      chk("R7 wrap irq", irq, 1);
    chk("R7 wrap no status", status, 0);
    mode_sel = 2'b11;
    cyc(0, 1, 32'd7, 0);  chk("R4 mode 11 level low", irq, 0);
    cyc(0, 1, 32'hF0000000, 0); chk("R4 mode 11 level high", irq, 1);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_count;
    t_status_mode;
    t_edge_mode;
    t_level_mode;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule